// File: doc/BRIEF.md
# ALU Output Shifter Stage

This stage sits behind an 8-bit multiplexer-style ALU and picks what reaches the write bus. The write bus can carry the ALU result unchanged, the ALU result shifted right by one place, or a data-bus byte that skips the ALU entirely. No microcode bit is spent on the shift request. Instead, an operand-select code that the ALU never uses as a real input choice stands for it. The stage spots that code, starts the shift, and passes a neutral code of all zeros on to the ALU input multiplexer.

Each shift is one of two kinds: a logical shift fills the top bit with zero, and a rotate fills it with the carry flag. The bit that falls out at the bottom becomes the carry output. When no shift happens, the ALU's own carry goes through. The path choice is combinational. The write-bus byte and the carry can be registered (`REG_OUT`, default on) so the stage can be checked on a clock. The corrected select code stays combinational because the ALU consumes it in the same cycle.

The path choice works like a small three-state selector, evaluated every cycle with no memory:
- PATH_BYPASS is taken whenever the bypass enable is high.
- PATH_SHIFT is taken when there is no bypass and the select code equals the reserved shift code.
- PATH_PASS covers every other case.

Top module: `alu_out_shifter`

## Requirements
- R1: On PATH_SHIFT, write-bus bit i equals ALU result bit i+1 for i = 0..6.
- R2: On PATH_PASS, the write bus equals the ALU result and the carry output equals the ALU carry.
- R3: On PATH_SHIFT, write-bus bit 7 equals the carry-in flag when the rotate select is 1, and 0 when it is 0.
- R4: Select code 4'b0001 is the shift request: it selects PATH_SHIFT (unless bypassed) and is sent on to the ALU as 4'b0000. Every other code is sent on unchanged and requests no shift.
- R5: On PATH_SHIFT, the carry output equals bit 0 of the ALU result.
- R6: When the bypass enable is 1, the write bus equals the data-bus byte and the carry output equals the ALU carry. This holds whatever the select code and rotate select are, and the select-code correction of R4 still applies.
- R7: The rotate select has no effect on the write bus or the carry when no shift is requested.
- R8: With `REG_OUT` = 1, the write bus and carry show the result of the inputs sampled at the previous rising clock edge. They are 0 while reset is asserted.
- R9: The corrected select code follows the select input within the same cycle, with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res | input | 8 | ALU result byte |
| alu_cout | input | 1 | ALU carry out |
| carry_in | input | 1 | Carry flag, used as the rotate fill bit |
| db_byte | input | 8 | Data-bus byte for the bypass path |
| sel_code | input | 4 | ALU operand-select code from microcode |
| rotate_en | input | 1 | 1 = rotate (fill from carry), 0 = logical (fill zero) |
| bypass_en | input | 1 | Drive the data-bus byte onto the write bus |
| wb_out | output | 8 | Write-bus value |
| carry_out | output | 1 | Carry from the shift, or the ALU carry otherwise |
| sel_to_alu | output | 4 | Corrected select code for the ALU input multiplexer |

## Verification
The hardest case to reach is the conflict where the reserved shift code arrives together with the bypass enable. In that case the select correction must still zero the code while the shift result is thrown away. Table rows set up this combination on purpose, with the rotate select on and a nonzero carry, so that a wrong priority or a skipped correction shows on the bus. A sweep over all sixteen select codes checks that only the reserved code triggers a shift. A check taken just before a clock edge confirms that the registered output has not yet moved.

// File: rtl/shs_pkg.sv
package shs_pkg;

    typedef enum logic [1:0] {
        PATH_PASS   = 2'd0,
        PATH_SHIFT  = 2'd1,
        PATH_BYPASS = 2'd2
    } path_e;

    typedef enum logic {
        FILL_ZERO  = 1'b0,
        FILL_CARRY = 1'b1
    } fill_e;

endpackage

// File: rtl/shs_sel_decode.sv
module shs_sel_decode
    import shs_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter logic [SEL_W-1:0] SHIFT_CODE = 1
) (
    input  logic [SEL_W-1:0] sel_code,
    input  logic             bypass_en,
    output logic [SEL_W-1:0] sel_fwd,
    output path_e            path
);
    localparam logic [SEL_W-1:0] NEUTRAL = '0;

    logic shift_hit;

    always_comb begin
        shift_hit = (sel_code == SHIFT_CODE);
        sel_fwd   = shift_hit ? NEUTRAL : sel_code;
        if (bypass_en)      path = PATH_BYPASS;
        else if (shift_hit) path = PATH_SHIFT;
        else                path = PATH_PASS;
    end
endmodule

// File: rtl/shs_shifter.sv
module shs_shifter
    import shs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  fill_e        mode,
    input  logic         carry_in,
    output logic [W-1:0] shifted,
    output logic         lsb_out
);
    logic fill_bit;

    always_comb begin
        unique case (mode)
            FILL_CARRY: fill_bit = carry_in;
            FILL_ZERO:  fill_bit = 1'b0;
            default:    fill_bit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign shifted[i] = val[i+1];
    end
    assign shifted[W-1] = fill_bit;
    assign lsb_out      = val[0];
endmodule

// File: rtl/shs_out_select.sv
module shs_out_select
    import shs_pkg::*;
#(
    parameter int W = 8
) (
    input  path_e        path,
    input  logic [W-1:0] alu_res,
    input  logic         alu_cout,
    input  logic [W-1:0] db_byte,
    input  logic [W-1:0] shifted,
    input  logic         shift_c,
    output logic [W-1:0] wb_nxt,
    output logic         c_nxt
);
    always_comb begin
        unique case (path)
            PATH_BYPASS: begin
                wb_nxt = db_byte;
                c_nxt  = alu_cout;
            end
            PATH_SHIFT: begin
                wb_nxt = shifted;
                c_nxt  = shift_c;
            end
            default: begin
                wb_nxt = alu_res;
                c_nxt  = alu_cout;
            end
        endcase
    end
endmodule

// File: rtl/alu_out_shifter.sv
module alu_out_shifter
    import shs_pkg::*;
#(
    parameter int W       = 8,
    parameter int SEL_W   = 4,
    parameter int REG_OUT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     alu_res,
    input  logic             alu_cout,
    input  logic             carry_in,
    input  logic [W-1:0]     db_byte,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             rotate_en,
    input  logic             bypass_en,
    output logic [W-1:0]     wb_out,
    output logic             carry_out,
    output logic [SEL_W-1:0] sel_to_alu
);
    localparam logic [SEL_W-1:0] SHR_CODE = SEL_W'(1);

    path_e        path;
    fill_e        fill_mode;
    logic [W-1:0] shifted;
    logic         shift_c;
    logic [W-1:0] wb_nxt;
    logic         c_nxt;

    assign fill_mode = rotate_en ? FILL_CARRY : FILL_ZERO;

    shs_sel_decode #(.SEL_W(SEL_W), .SHIFT_CODE(SHR_CODE)) u_dec (
        .sel_code (sel_code),
        .bypass_en(bypass_en),
        .sel_fwd  (sel_to_alu),
        .path     (path)
    );

    shs_shifter #(.W(W)) u_shr (
        .val     (alu_res),
        .mode    (fill_mode),
        .carry_in(carry_in),
        .shifted (shifted),
        .lsb_out (shift_c)
    );

    shs_out_select #(.W(W)) u_sel (
        .path    (path),
        .alu_res (alu_res),
        .alu_cout(alu_cout),
        .db_byte (db_byte),
        .shifted (shifted),
        .shift_c (shift_c),
        .wb_nxt  (wb_nxt),
        .c_nxt   (c_nxt)
    );

    if (REG_OUT != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wb_out    <= '0;
                carry_out <= 1'b0;
            end else begin
                wb_out    <= wb_nxt;
                carry_out <= c_nxt;
            end
        end

        a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_en && sel_code != SHR_CODE)
            |=> (wb_out == $past(alu_res) && carry_out == $past(alu_cout)));

        a_r1_logical_shift: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_en && sel_code == SHR_CODE && !rotate_en)
            |=> (wb_out == {1'b0, $past(alu_res[W-1:1])}));

        a_r3_rotate_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_en && sel_code == SHR_CODE && rotate_en)
            |=> (wb_out[W-1] == $past(carry_in)));

        a_r5_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_en && sel_code == SHR_CODE)
            |=> (carry_out == $past(alu_res[0])));

        a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            bypass_en |=> (wb_out == $past(db_byte) && carry_out == $past(alu_cout)));
    end else begin : g_comb
        assign wb_out    = wb_nxt;
        assign carry_out = c_nxt;

        a_r6_bypass_comb: assert property (@(posedge clk) disable iff (!rst_n)
            bypass_en |-> (wb_out == db_byte));
    end

    a_r4_code_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == SHR_CODE) |-> (sel_to_alu == '0));

    a_r4_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != SHR_CODE) |-> (sel_to_alu == sel_code));
endmodule

// File: tb/alu_out_shifter_tb.sv
module alu_out_shifter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] alu_res = '0;
    logic       alu_cout = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] db_byte = '0;
    logic [3:0] sel_code = '0;
    logic       rotate_en = 1'b0;
    logic       bypass_en = 1'b0;
    logic [7:0] wb_out;
    logic       carry_out;
    logic [3:0] sel_to_alu;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu_out_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_cout(alu_cout),
        .carry_in(carry_in), .db_byte(db_byte), .sel_code(sel_code),
        .rotate_en(rotate_en), .bypass_en(bypass_en), .wb_out(wb_out),
        .carry_out(carry_out), .sel_to_alu(sel_to_alu)
    );

    // {sel, rot, byp, alu, cin, acout, db, exp_wb, exp_c, exp_sel}
    localparam int NV = 10;
    localparam logic [36:0] VEC [NV] = '{
        {4'h2, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'h3C, 8'hA5, 1'b1, 4'h2}, // R2 pass
        {4'h1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, 8'h00, 8'h52, 1'b1, 4'h0}, // R1 R3 logical
        {4'h1, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0, 8'h00, 8'hD2, 1'b1, 4'h0}, // R3 rotate
        {4'h1, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 8'h00, 8'h40, 1'b0, 4'h0}, // R5 rotate cin 0
        {4'h1, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 4'h0}, // R5 logical lsb
        {4'h1, 1'b1, 1'b0, 8'hFE, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 4'h0}, // R3 rotate fill
        {4'h1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h5A, 8'h5A, 1'b1, 4'h0}, // R6 bypass over shift
        {4'h0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 8'hC3, 8'hC3, 1'b0, 4'h0}, // R6 bypass plain
        {4'hF, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h00, 8'h3C, 1'b0, 4'hF}, // R7 rotate ignored
        {4'h0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b1, 4'h0}  // R2 zero pass
    };

    function automatic string vtag(input int i);
        case (i)
            0, 9:    return "R2";
            1:       return "R1";
            2, 5:    return "R3";
            3, 4:    return "R5";
            6, 7:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8 reset state with nonzero inputs
        alu_res = 8'hFF; alu_cout = 1'b1; db_byte = 8'hAA; bypass_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 reset wb", wb_out, 8'h00);
        chk("R8 reset carry", {7'b0, carry_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {sel_code, rotate_en, bypass_en, alu_res, carry_in, alu_cout, db_byte} = VEC[i][36:13];
            #1;
            chk({"R9 sel ", vtag(i)}, {4'b0, sel_to_alu}, {4'b0, VEC[i][3:0]});
            @(negedge clk);
            chk({vtag(i), " wb"}, wb_out, VEC[i][12:5]);
            chk({vtag(i), " carry"}, {7'b0, carry_out}, {7'b0, VEC[i][4]});
        end

        // R4 sweep of all select codes: alu 81, cin 1, rotate on, acout 0
        alu_res = 8'h81; carry_in = 1'b1; rotate_en = 1'b1; alu_cout = 1'b0; bypass_en = 1'b0;
        for (int c = 0; c < 16; c++) begin
            sel_code = 4'(c);
            #1;
            chk("R4 sel fwd", {4'b0, sel_to_alu}, (c == 1) ? 8'h00 : 8'(c));
            @(negedge clk);
            chk("R4 wb", wb_out, (c == 1) ? 8'hC0 : 8'h81);
            chk("R4 carry", {7'b0, carry_out}, (c == 1) ? 8'h01 : 8'h00);
        end

        // R8 output holds until the next rising edge
        sel_code = 4'h3; alu_res = 8'h77; alu_cout = 1'b1;
        #2;
        chk("R8 hold wb", wb_out, 8'h81);
        @(negedge clk);
        chk("R8 update wb", wb_out, 8'h77);

        // R6 bypass with shift code still zeroes forwarded code
        sel_code = 4'h1; bypass_en = 1'b1; db_byte = 8'h0F;
        #1;
        chk("R6 sel fwd", {4'b0, sel_to_alu}, 8'h00);
        @(negedge clk);
        chk("R6 wb", wb_out, 8'h0F);

        finish_run();
    end
endmodule